// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Engine

This block multiplies two 16-bit two's-complement operands and folds the 32-bit product into a 40-bit accumulator. In accumulate mode the product is added to the accumulator. In multiply-only mode the product replaces it. A rounded 16-bit view of the accumulator, which can optionally be saturated, is kept up to date, together with four status flags. The operands are loaded one byte at a time through write strobes. Writing the low byte of the second operand (B) is the only event that starts an operation. A configuration write sets the mode and the saturation enable. It can also arm two self-clearing requests: a clear of the accumulator and flags that is tied to the next start, and a one-bit arithmetic shift of the accumulator.

An operation passes through three one-clock stages: multiply, accumulate, round. On every clock the control logic picks one accumulator action. The actions are HOLD, CLEAR, MAC (add the product), MUL (replace with the product), SHL (shift left) and SHR (shift right), in this priority order:
- CLEAR, when the operation in its first stage was started with the clear request armed.
- MAC or MUL, when an operation is in its second stage.
- SHL or SHR, when a shift is armed, no start strobe is present and no stage holds an operation.
- HOLD otherwise.

A new start may be issued on every clock, so one operation can be multiplied while the previous one is being accumulated.

Top module: `mac_engine`

## Requirements
- R1: Writes to the A low byte, the A high byte and the B high byte only load operand bytes (low byte is bits 7:0, high byte is bits 15:8). They never change the accumulator.
- R2: A write of the B low byte on clock edge S starts an operation. The signed product A*B is added to the 40-bit accumulator on edge S+2 (MAC action), using the operand values present after edge S.
- R3: With the multiply-only mode bit set when the operation starts, the accumulator is replaced by the sign-extended product on edge S+2 (MUL action), and the high-overflow flag keeps its value.
- R4: After each MAC or MUL action, the zero flag is 1 exactly when the accumulator is 0, and the sign flag equals accumulator bit 39.
- R5: After a MAC action, the high-overflow flag is 1 exactly when the new accumulator lies outside the signed 32-bit range.
- R6: The hard-overflow flag is set when a MAC addition overflows 40-bit signed arithmetic (the accumulator wraps). It then stays set until a CLEAR action.
- R7: If the clear request is armed when a start occurs on edge S, then on edge S+1 the accumulator and all four flags become 0 and the clear request drops to 0. A MAC or MUL action due on that same edge is discarded.
- R8: One clock after the accumulator changes, the rounded output shows accumulator bits 31:16 plus accumulator bit 15.
- R9: With saturation enabled, a rounded value above 32767 gives 0x7FFF and a value below -32768 gives 0x8000. With saturation disabled, the rounded value wraps to 16 bits.
- R10: A shift request shifts the accumulator by one bit in one clock. Direction 0 shifts left with a 0 fill. Direction 1 shifts right and repeats bit 39. Shifts leave all four flags unchanged.
- R11: A shift request waits, and stays pending, while a start strobe is present or any operation is in stage one or two. It executes on the first free edge, and then the request drops to 0.
- R12: Starts on consecutive clocks are all accumulated, each product exactly once.
- R13: After reset the accumulator, rounded output, flags and both pending requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Byte written by the operand strobes |
| wr_a_lo | input | 1 | Load A bits 7:0 |
| wr_a_hi | input | 1 | Load A bits 15:8 |
| wr_b_lo | input | 1 | Load B bits 7:0 and start an operation |
| wr_b_hi | input | 1 | Load B bits 15:8 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mult_only | input | 1 | 1 selects multiply-only mode |
| cfg_sat_en | input | 1 | 1 enables saturation of the rounded output |
| cfg_clear | input | 1 | Arms the clear request |
| cfg_shift | input | 1 | Arms the shift request |
| cfg_shift_right | input | 1 | Shift direction, 1 selects right |
| acc | output | 40 | Accumulator |
| rnd | output | 16 | Rounded, optionally saturated result |
| flag_zero | output | 1 | Accumulator is zero |
| flag_sign | output | 1 | Accumulator is negative |
| flag_hi_ovf | output | 1 | Result is outside the 32-bit signed range |
| flag_hard_ovf | output | 1 | Sticky 40-bit overflow |
| clear_pending | output | 1 | Clear request still armed |
| shift_pending | output | 1 | Shift request still armed |

## Verification
The properties assume that a configuration write never falls on the same clock as a CLEAR action or a held shift. A configuration write overwrites both request bits, so on such a clock the self-clearing behaviour would be masked. The stimulus therefore issues configuration writes only when the pipeline is empty, with one exception: in the shift-priority case the configuration write comes on the clock before the start strobe. Operand writes and starts are otherwise unrestricted, including starts on consecutive clocks.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_CLEAR,
        ACC_MAC,
        ACC_MUL,
        ACC_SHL,
        ACC_SHR
    } acc_op_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic hi_ovf;
        logic hard_ovf;
    } mac_flags_t;

endpackage

// File: rtl/mac_operands.sv
module mac_operands #(
    parameter int OP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W/2-1:0] wr_data,
    input  logic [1:0]        a_we,
    input  logic [1:0]        b_we,
    output logic [OP_W-1:0]   op_a,
    output logic [OP_W-1:0]   op_b
);
    localparam int LANE_W = OP_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (a_we[k]) op_a[k*LANE_W +: LANE_W] <= wr_data;
                if (b_we[k]) op_b[k*LANE_W +: LANE_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int OP_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OP_W-1:0]       op_a,
    input  logic [OP_W-1:0]       op_b,
    input  logic                  s0_v,
    input  logic                  s0_mo,
    output logic signed [2*OP_W-1:0] prod_q,
    output logic                  s1_v,
    output logic                  s1_mo
);
    localparam int PROD_W = 2 * OP_W;

    logic signed [PROD_W-1:0] prod_c;

    always_comb begin
        prod_c = PROD_W'($signed(op_a)) * PROD_W'($signed(op_b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            s1_v   <= 1'b0;
            s1_mo  <= 1'b0;
        end else begin
            s1_v  <= s0_v;
            s1_mo <= s0_mo;
            if (s0_v) prod_q <= prod_c;
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  mac_pkg::acc_op_e          acc_op,
    input  logic signed [2*OP_W-1:0]  prod,
    output logic [ACC_W-1:0]          acc_q,
    output mac_pkg::mac_flags_t       flags_q
);
    import mac_pkg::*;

    localparam int PROD_W = 2 * OP_W;

    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W:0]   sum_w;
    logic                    ovf_now;
    logic                    hi_now;

    always_comb begin
        prod_ext = ACC_W'(prod);
        sum_w    = {acc_q[ACC_W-1], acc_q} + {prod_ext[ACC_W-1], prod_ext};
        ovf_now  = sum_w[ACC_W] != sum_w[ACC_W-1];
        hi_now   = !((&sum_w[ACC_W-1:PROD_W-1]) || !(|sum_w[ACC_W-1:PROD_W-1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else begin
            unique case (acc_op)
                ACC_HOLD: ;
                ACC_CLEAR: begin
                    acc_q   <= '0;
                    flags_q <= '0;
                end
                ACC_MAC: begin
                    acc_q            <= sum_w[ACC_W-1:0];
                    flags_q.zero     <= sum_w[ACC_W-1:0] == '0;
                    flags_q.sign     <= sum_w[ACC_W-1];
                    flags_q.hi_ovf   <= hi_now;
                    flags_q.hard_ovf <= flags_q.hard_ovf | ovf_now;
                end
                ACC_MUL: begin
                    acc_q        <= prod_ext;
                    flags_q.zero <= prod_ext == '0;
                    flags_q.sign <= prod_ext[ACC_W-1];
                end
                ACC_SHL: acc_q <= {acc_q[ACC_W-2:0], 1'b0};
                ACC_SHR: acc_q <= {acc_q[ACC_W-1], acc_q[ACC_W-1:1]};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mac_round.sv
module mac_round #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    input  logic             sat_en,
    output logic [OUT_W-1:0] rnd_q
);
    localparam int HI_W = ACC_W - OUT_W;
    localparam logic signed [HI_W:0] MAXV = (HI_W+1)'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [HI_W:0] MINV = -MAXV - (HI_W+1)'(1);

    logic signed [HI_W:0] r_w;
    logic [OUT_W-1:0]     r_out;

    always_comb begin
        r_w = $signed({acc[ACC_W-1], acc[ACC_W-1:OUT_W]}) + $signed({{HI_W{1'b0}}, acc[OUT_W-1]});
        if (sat_en && (r_w > MAXV))
            r_out = {1'b0, {(OUT_W-1){1'b1}}};
        else if (sat_en && (r_w < MINV))
            r_out = {1'b1, {(OUT_W-1){1'b0}}};
        else
            r_out = r_w[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd_q <= '0;
        else        rnd_q <= r_out;
    end

endmodule

// File: rtl/mac_engine.sv
module mac_engine #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W/2-1:0]  wr_data,
    input  logic               wr_a_lo,
    input  logic               wr_a_hi,
    input  logic               wr_b_lo,
    input  logic               wr_b_hi,
    input  logic               cfg_wr,
    input  logic               cfg_mult_only,
    input  logic               cfg_sat_en,
    input  logic               cfg_clear,
    input  logic               cfg_shift,
    input  logic               cfg_shift_right,
    output logic [ACC_W-1:0]   acc,
    output logic [OUT_W-1:0]   rnd,
    output logic               flag_zero,
    output logic               flag_sign,
    output logic               flag_hi_ovf,
    output logic               flag_hard_ovf,
    output logic               clear_pending,
    output logic               shift_pending
);
    import mac_pkg::*;

    localparam int PROD_W = 2 * OP_W;

    logic [OP_W-1:0]          op_a;
    logic [OP_W-1:0]          op_b;
    logic signed [PROD_W-1:0] prod_q;
    logic                     s0_v, s0_mo, s0_clr;
    logic                     s1_v, s1_mo;
    logic                     mode_mo, sat_en, shift_dir;
    logic                     clr_pend, shift_pend;
    acc_op_e                  acc_op;
    mac_flags_t               flags_q;
    logic [ACC_W-1:0]         acc_q;

    mac_operands #(.OP_W(OP_W)) u_ops (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .a_we    ({wr_a_hi, wr_a_lo}),
        .b_we    ({wr_b_hi, wr_b_lo}),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    mac_mult #(.OP_W(OP_W)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .s0_v   (s0_v),
        .s0_mo  (s0_mo),
        .prod_q (prod_q),
        .s1_v   (s1_v),
        .s1_mo  (s1_mo)
    );

    // Action selection: clear, then the stage-two write, then a shift.
    always_comb begin
        acc_op = ACC_HOLD;
        if (s0_v && s0_clr)
            acc_op = ACC_CLEAR;
        else if (s1_v)
            acc_op = s1_mo ? ACC_MUL : ACC_MAC;
        else if (shift_pend && !wr_b_lo && !s0_v)
            acc_op = shift_dir ? ACC_SHR : ACC_SHL;
    end

    // Control state register: configuration, requests and stage-zero tags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_mo    <= 1'b0;
            sat_en     <= 1'b0;
            shift_dir  <= 1'b0;
            clr_pend   <= 1'b0;
            shift_pend <= 1'b0;
            s0_v       <= 1'b0;
            s0_mo      <= 1'b0;
            s0_clr     <= 1'b0;
        end else begin
            s0_v   <= wr_b_lo;
            s0_mo  <= mode_mo;
            s0_clr <= clr_pend & wr_b_lo;
            if (cfg_wr) begin
                mode_mo    <= cfg_mult_only;
                sat_en     <= cfg_sat_en;
                shift_dir  <= cfg_shift_right;
                clr_pend   <= cfg_clear;
                shift_pend <= cfg_shift;
            end else begin
                if (acc_op == ACC_CLEAR) clr_pend <= 1'b0;
                if (acc_op == ACC_SHL || acc_op == ACC_SHR) shift_pend <= 1'b0;
            end
        end
    end

    mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_op  (acc_op),
        .prod    (prod_q),
        .acc_q   (acc_q),
        .flags_q (flags_q)
    );

    mac_round #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_rnd (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc_q),
        .sat_en (sat_en),
        .rnd_q  (rnd)
    );

    always_comb begin
        acc           = acc_q;
        flag_zero     = flags_q.zero;
        flag_sign     = flags_q.sign;
        flag_hi_ovf   = flags_q.hi_ovf;
        flag_hard_ovf = flags_q.hard_ovf;
        clear_pending = clr_pend;
        shift_pending = shift_pend;
    end

endmodule

// File: rtl/mac_engine_chk.sv
module mac_engine_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input mac_pkg::acc_op_e acc_op,
    input logic [ACC_W-1:0] acc,
    input logic             flag_zero,
    input logic             flag_sign,
    input logic             flag_hi_ovf,
    input logic             flag_hard_ovf,
    input logic             clear_pending,
    input logic             shift_pending,
    input logic             cfg_wr,
    input logic             wr_b_lo,
    input logic             s0_v,
    input logic             s1_v
);
    import mac_pkg::*;

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == ACC_CLEAR && !cfg_wr) |=>
        (acc == '0 && !flag_zero && !flag_sign && !flag_hi_ovf && !flag_hard_ovf && !clear_pending));

    a_r10_shift_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == ACC_SHL || acc_op == ACC_SHR) |=>
        $stable({flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf}));

    a_r10_right_shift_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == ACC_SHR) |=> (acc[ACC_W-1] == $past(acc[ACC_W-1])));

    a_r3_mul_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == ACC_MUL) |=> $stable(flag_hi_ovf));

    a_r6_hard_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hard_ovf && acc_op != ACC_CLEAR) |=> flag_hard_ovf);

    a_r4_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == ACC_MAC || acc_op == ACC_MUL) |=> (flag_sign == acc[ACC_W-1]));

    a_r11_shift_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pending && !cfg_wr && (wr_b_lo || s0_v || s1_v)) |=> shift_pending);

endmodule

bind mac_engine mac_engine_chk #(.ACC_W(ACC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_op        (acc_op),
    .acc           (acc),
    .flag_zero     (flag_zero),
    .flag_sign     (flag_sign),
    .flag_hi_ovf   (flag_hi_ovf),
    .flag_hard_ovf (flag_hard_ovf),
    .clear_pending (clear_pending),
    .shift_pending (shift_pending),
    .cfg_wr        (cfg_wr),
    .wr_b_lo       (wr_b_lo),
    .s0_v          (s0_v),
    .s1_v          (s1_v)
);

// File: tb/mac_engine_tb_top.sv
module mac_engine_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]  wr_data = '0;
    logic        wr_a_lo = 0, wr_a_hi = 0, wr_b_lo = 0, wr_b_hi = 0;
    logic        cfg_wr = 0, cfg_mult_only = 0, cfg_sat_en = 0, cfg_clear = 0, cfg_shift = 0, cfg_shift_right = 0;
    logic [39:0] acc;
    logic [15:0] rnd;
    logic        flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf, clear_pending, shift_pending;

    mac_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_a_lo(wr_a_lo), .wr_a_hi(wr_a_hi), .wr_b_lo(wr_b_lo), .wr_b_hi(wr_b_hi),
        .cfg_wr(cfg_wr), .cfg_mult_only(cfg_mult_only), .cfg_sat_en(cfg_sat_en),
        .cfg_clear(cfg_clear), .cfg_shift(cfg_shift), .cfg_shift_right(cfg_shift_right),
        .acc(acc), .rnd(rnd), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_hi_ovf(flag_hi_ovf), .flag_hard_ovf(flag_hard_ovf),
        .clear_pending(clear_pending), .shift_pending(shift_pending)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R13";
    bit    done = 0;

    task automatic chk(input string what, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    typedef struct { longint prod; bit mo; bit clr; int age; } pend_t;
    pend_t       pend[$];
    longint      m_acc;
    logic [15:0] m_a, m_b, m_rnd;
    bit          m_z, m_s, m_h, m_o, m_mo, m_sat, m_dir, m_clrp, m_shp;

    function automatic longint wrap40(input longint v);
        longint m;
        longint r;
        m = longint'(1) <<< 40;
        r = v & (m - 1);
        if (r[39]) r = r - m;
        return r;
    endfunction

    function automatic logic [15:0] round_of(input longint a, input bit sat);
        longint r;
        r = (a >>> 16) + ((a >> 15) & 1);
        if (sat && r > 32767) r = 32767;
        if (sat && r < -32768) r = -32768;
        return r[15:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            m_acc = 0; m_a = 0; m_b = 0; m_rnd = 0;
            m_z = 0; m_s = 0; m_h = 0; m_o = 0;
            m_mo = 0; m_sat = 0; m_dir = 0; m_clrp = 0; m_shp = 0;
        end else begin
            logic [15:0] nr;
            bit old_mo, old_clrp, busy, cleared;
            longint s;
            nr = round_of(m_acc, m_sat);
            old_mo = m_mo; old_clrp = m_clrp;
            busy = pend.size() != 0;
            cleared = 0;
            foreach (pend[i]) pend[i].age++;
            foreach (pend[i]) if (pend[i].age == 1 && pend[i].clr) cleared = 1;
            if (cleared) begin
                m_acc = 0; m_z = 0; m_s = 0; m_h = 0; m_o = 0; m_clrp = 0;
            end
            if (pend.size() != 0 && pend[0].age == 2) begin
                if (!cleared) begin
                    if (pend[0].mo) m_acc = pend[0].prod;
                    else begin
                        s = m_acc + pend[0].prod;
                        if (s > ((longint'(1) <<< 39) - 1) || s < -(longint'(1) <<< 39)) m_o = 1;
                        m_acc = wrap40(s);
                        m_h = (m_acc > ((longint'(1) <<< 31) - 1)) || (m_acc < -(longint'(1) <<< 31));
                    end
                    m_z = (m_acc == 0);
                    m_s = (m_acc < 0);
                end
                void'(pend.pop_front());
            end
            if (!busy && !wr_b_lo && m_shp) begin
                if (m_dir) m_acc = m_acc >>> 1;
                else       m_acc = wrap40(m_acc <<< 1);
                m_shp = 0;
            end
            if (wr_a_lo) m_a[7:0]  = wr_data;
            if (wr_a_hi) m_a[15:8] = wr_data;
            if (wr_b_lo) m_b[7:0]  = wr_data;
            if (wr_b_hi) m_b[15:8] = wr_data;
            if (wr_b_lo)
                pend.push_back('{longint'($signed(m_a)) * longint'($signed(m_b)), old_mo, old_clrp, 0});
            if (cfg_wr) begin
                m_mo = cfg_mult_only; m_sat = cfg_sat_en; m_dir = cfg_shift_right;
                m_clrp = cfg_clear; m_shp = cfg_shift;
            end
            m_rnd = nr;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model acc", acc, m_acc[39:0]);
            chk("model rnd", 40'(rnd), 40'(m_rnd));
            chk("model flags", 40'({flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf}), 40'({m_z, m_s, m_h, m_o}));
            chk("model pending", 40'({clear_pending, shift_pending}), 40'({m_clrp, m_shp}));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input int which, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_a_lo = (which == 0); wr_a_hi = (which == 1);
        wr_b_lo = (which == 2); wr_b_hi = (which == 3);
        @(negedge clk);
        wr_a_lo = 0; wr_a_hi = 0; wr_b_lo = 0; wr_b_hi = 0;
    endtask

    task automatic cfg(input bit mo, input bit sat, input bit clr, input bit sh, input bit dir);
        @(negedge clk);
        cfg_wr = 1; cfg_mult_only = mo; cfg_sat_en = sat;
        cfg_clear = clr; cfg_shift = sh; cfg_shift_right = dir;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] b);
        put(0, a[7:0]); put(1, a[15:8]); put(3, b[15:8]); put(2, b[7:0]);
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        cur_req = "R13";
        chk("reset acc", acc, 40'd0);
        chk("reset rnd", 40'(rnd), 40'd0);
        chk("reset flags", 40'({flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf}), 40'd0);
        chk("reset pending", 40'({clear_pending, shift_pending}), 40'd0);

        cfg(0, 0, 0, 0, 0);
        cur_req = "R1";
        put(0, 8'd5); put(1, 8'd0); put(3, 8'd0);
        idle(4);
        chk("no start on other bytes", acc, 40'd0);
        cur_req = "R2";
        put(2, 8'd7);
        idle(4);
        chk("first product", acc, 40'd35);
        load(16'd3, 16'd4);
        chk("accumulated", acc, 40'd47);
        cur_req = "R8";
        chk("small rounded", 40'(rnd), 40'd0);

        cur_req = "R4";
        load(16'hFFFE, 16'd100);
        chk("negative acc", acc, 40'hFFFFFFFF67);
        chk("sign flag", 40'(flag_sign), 40'd1);
        chk("zero flag", 40'(flag_zero), 40'd0);

        cur_req = "R7";
        cfg(0, 0, 1, 0, 0);
        chk("clear armed", 40'(clear_pending), 40'd1);
        load(16'd2, 16'd3);
        chk("acc after clear", acc, 40'd6);
        chk("clear self-reset", 40'(clear_pending), 40'd0);

        cur_req = "R5";
        load(16'h7FFF, 16'h7FFF);
        load(16'h7FFF, 16'h7FFF);
        chk("still in 32 bits", 40'(flag_hi_ovf), 40'd0);
        load(16'h7FFF, 16'h7FFF);
        chk("acc past 32 bits", acc, 40'h00BFFD0009);
        chk("hi overflow set", 40'(flag_hi_ovf), 40'd1);
        cur_req = "R9";
        chk("wrapped rounding", 40'(rnd), 40'h0BFFD);
        cfg(0, 1, 0, 0, 0);
        idle(2);
        chk("positive saturation", 40'(rnd), 40'h07FFF);

        cur_req = "R3";
        cfg(1, 1, 0, 0, 0);
        load(16'h0100, 16'h0080);
        chk("product replaces", acc, 40'h8000);
        chk("hi overflow kept", 40'(flag_hi_ovf), 40'd1);
        cur_req = "R8";
        chk("round half up", 40'(rnd), 40'd1);

        cur_req = "R10";
        cfg(0, 0, 0, 1, 0);
        idle(2);
        chk("shift left", acc, 40'h10000);
        chk("flags kept on shift", 40'({flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf}), 40'b0010);
        cfg(0, 0, 0, 1, 1);
        idle(2);
        chk("shift right", acc, 40'h8000);
        cfg(1, 0, 0, 0, 0);
        load(16'hFFFF, 16'd3);
        cfg(0, 0, 0, 1, 1);
        idle(2);
        chk("right shift fills sign", acc, 40'hFFFFFFFFFE);
        chk("sign kept", 40'(flag_sign), 40'd1);

        cur_req = "R6";
        cfg(0, 0, 1, 0, 0);
        load(16'h7FFF, 16'h7FFF);
        for (int i = 0; i < 9; i++) begin
            cfg(0, 0, 0, 1, 0);
            idle(2);
        end
        chk("nine left shifts", acc, 40'h7FFE000200);
        load(16'h7FFF, 16'h7FFF);
        chk("wrapped sum", acc, 40'h803DFF0201);
        chk("hard overflow set", 40'(flag_hard_ovf), 40'd1);
        load(16'd1, 16'd1);
        chk("hard overflow sticky", 40'(flag_hard_ovf), 40'd1);
        cur_req = "R9";
        cfg(0, 1, 0, 0, 0);
        idle(2);
        chk("negative saturation", 40'(rnd), 40'h08000);
        cur_req = "R7";
        cfg(0, 0, 1, 0, 0);
        load(16'd0, 16'd0);
        chk("acc zero after clear", acc, 40'd0);
        chk("flags after clear", 40'({flag_zero, flag_sign, flag_hi_ovf, flag_hard_ovf}), 40'b1000);

        cur_req = "R11";
        put(0, 8'd3);
        @(negedge clk);
        cfg_wr = 1; cfg_mult_only = 0; cfg_sat_en = 0; cfg_clear = 0; cfg_shift = 1; cfg_shift_right = 0;
        @(negedge clk);
        cfg_wr = 0; wr_data = 8'd5; wr_b_lo = 1;
        @(negedge clk);
        wr_b_lo = 0;
        chk("shift held by start", 40'(shift_pending), 40'd1);
        idle(5);
        chk("shift after drain", acc, 40'd30);
        chk("shift request cleared", 40'(shift_pending), 40'd0);

        cur_req = "R12";
        put(0, 8'd2);
        @(negedge clk);
        wr_data = 8'd1; wr_b_lo = 1;
        @(negedge clk);
        wr_data = 8'd2;
        @(negedge clk);
        wr_data = 8'd3;
        @(negedge clk);
        wr_b_lo = 0;
        idle(5);
        chk("back to back sum", acc, 40'd42);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule